// File: doc/BRIEF.md
# Byte-Wide Multicycle Load/Store Processor Core

This block is a small multicycle processor whose datapath, ALU and general registers are all 8 bits wide. It runs a nine-instruction subset of a well-known 32-bit RISC instruction set: byte load, byte store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and unconditional jump. Code and data share one external byte-wide memory. The core reaches that memory through an address bus, a write-data bus, a combinational read-data bus and a single write strobe.

A controller state machine steps a datapath of registers, adders and multiplexers through fetch, decode, execute, memory access and writeback. The memory path is only one byte wide, so every 32-bit instruction word is collected over four consecutive fetch cycles before it is decoded. The register file has eight entries, so only the low three bits of each 5-bit register field are used. Register 0 is hardwired to zero.

Top module: `byte_cpu`

## Requirements
- R1: A synchronous active-high `rst` returns the controller to the first fetch cycle and clears the program counter to 0. In the cycle after any reset edge, `mem_addr` is 0 and `mem_we` is 0.
- R2: Each instruction is fetched as four byte reads from the program counter address and the three addresses after it. The program counter advances by one per byte. The first byte fills instruction bits 7:0 and the fourth fills bits 31:24.
- R3: An instruction with opcode (bits 31:26) equal to 0 and function field (bits 5:0) equal to 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs&rt or rs|rt (modulo 256) into rd. The fields are rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11.
- R4: Opcode 0 with function field 0x2A writes 1 into rd when rs is less than rt as signed 8-bit numbers, and 0 otherwise.
- R5: Opcode 0x20 loads the byte at address rs + imm[7:0] into rt, where the immediate occupies bits 15:0.
- R6: Opcode 0x28 writes rt to address rs + imm[7:0]. `mem_we` is high for exactly one cycle per store, with the address and data valid in that cycle.
- R7: Opcode 0x04 compares rs with rt. When they are equal, the program counter becomes the address of the following instruction plus the sign-extended immediate shifted left by two, truncated to 8 bits. Otherwise execution continues in sequence.
- R8: Opcode 0x02 loads the program counter with the low six bits of the target field (bits 25:0) shifted left by two.
- R9: Register 0 always reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Byte address for instruction fetch or data access |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 8 | Combinational read data for `mem_addr` |

## Verification
The bench drives table vectors through an ALU program that includes unsigned wrap on add and subtract and the signed edge cases of set-less-than at 0x80 against 0x7F and at equal operands. A core that compared without sign would report 0x80 < 0x7F as false and fail these vectors. Directed programs cover a branch that is taken and one that is not, a backward branch with offset -1 that must wrap to loop on itself, and a jump that must skip a store. A wrong sign extension or a wrong base for the branch target would run the store that should be skipped, or leave the loop. Separate programs write to register 0 and load through a non-zero base register, and they check the strobe count, the fetch address order and reset in the middle of a program.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int XLEN        = 8;
    localparam int INSTR_W     = 32;
    localparam int NREGS       = 8;
    localparam int RIDX_W      = $clog2(NREGS);
    localparam int FETCH_BEATS = INSTR_W / XLEN;
    localparam int BEAT_W      = $clog2(FETCH_BEATS);

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_JMP   = 6'h02;
    localparam logic [5:0] OP_BREQ  = 6'h04;
    localparam logic [5:0] OP_LDB   = 6'h20;
    localparam logic [5:0] OP_STB   = 6'h28;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_LOAD, ST_LOADWB,
        ST_STORE, ST_EXEC, ST_EXECWB, ST_BRANCH, ST_JUMP
    } cpu_state_e;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] sh;
        logic [5:0] fn;
    } instr_t;

    typedef struct packed {
        logic fetch;
        logic decode;
        logic addr_calc;
        logic load_rd;
        logic store;
        logic exec;
        logic wb_mem;
        logic wb_alu;
        logic branch;
        logic jump;
    } ctrl_t;

    function automatic logic [15:0] imm_of(instr_t i);
        return {i.rd, i.sh, i.fn};
    endfunction

    function automatic alu_op_e alu_from_fn(logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction
endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = W'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NREGS,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] bank [N];

    // Entry 0 is never stored; it reads as zero (R9)
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst || i == 0)
                bank[i] <= '0;
            else if (we && wa == AW'(i))
                bank[i] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : bank[ra1];
    assign rd2 = (ra2 == '0) ? '0 : bank[ra2];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        opcode,
    output ctrl_t             ctl,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(FETCH_BEATS - 1);

    cpu_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_FETCH:  if (beat == LAST_BEAT) state_nx = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_LDB, OP_STB: state_nx = ST_ADDR;
                    OP_REG:         state_nx = ST_EXEC;
                    OP_BREQ:        state_nx = ST_BRANCH;
                    OP_JMP:         state_nx = ST_JUMP;
                    default:        state_nx = ST_FETCH;
                endcase
            end
            ST_ADDR:   state_nx = (opcode == OP_LDB) ? ST_LOAD : ST_STORE;
            ST_LOAD:   state_nx = ST_LOADWB;
            ST_EXEC:   state_nx = ST_EXECWB;
            default:   state_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            beat  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_FETCH)
                beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
        end
    end

    always_comb begin
        ctl = '0;
        case (state)
            ST_FETCH:  ctl.fetch     = 1'b1;
            ST_DECODE: ctl.decode    = 1'b1;
            ST_ADDR:   ctl.addr_calc = 1'b1;
            ST_LOAD:   ctl.load_rd   = 1'b1;
            ST_LOADWB: ctl.wb_mem    = 1'b1;
            ST_STORE:  ctl.store     = 1'b1;
            ST_EXEC:   ctl.exec      = 1'b1;
            ST_EXECWB: ctl.wb_alu    = 1'b1;
            ST_BRANCH: ctl.branch    = 1'b1;
            ST_JUMP:   ctl.jump      = 1'b1;
            default:   ctl = '0;
        endcase
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_FETCH && beat == '0));

    assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && beat == LAST_BEAT) |=> (state == ST_DECODE));
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
    import cpu_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    output logic [cpu_pkg::XLEN-1:0]  mem_addr,
    output logic [cpu_pkg::XLEN-1:0]  mem_wdata,
    output logic                      mem_we,
    input  logic [cpu_pkg::XLEN-1:0]  mem_rdata
);
    ctrl_t              ctl;
    logic [BEAT_W-1:0]  beat;
    logic [INSTR_W-1:0] ir_word;
    instr_t             ins;
    logic [15:0]        imm;

    logic [XLEN-1:0] pc, a_q, b_q, alu_q, mdr_q, tgt_q;
    logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, wb_data;
    logic [RIDX_W-1:0] wb_idx;
    alu_op_e alu_op;

    // Instruction register, one byte lane per fetch beat, low lane first
    for (genvar k = 0; k < FETCH_BEATS; k++) begin : g_lane
        logic [XLEN-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (ctl.fetch && beat == BEAT_W'(k))
                lane_q <= mem_rdata;
        end
        assign ir_word[k*XLEN +: XLEN] = lane_q;
    end

    assign ins = instr_t'(ir_word);
    assign imm = imm_of(ins);

    cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ins.op),
        .ctl    (ctl),
        .beat   (beat)
    );

    assign wb_idx  = ctl.wb_mem ? ins.rt[RIDX_W-1:0] : ins.rd[RIDX_W-1:0];
    assign wb_data = ctl.wb_mem ? mdr_q : alu_q;

    cpu_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ins.rs[RIDX_W-1:0]),
        .ra2 (ins.rt[RIDX_W-1:0]),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (ctl.wb_mem | ctl.wb_alu),
        .wa  (wb_idx),
        .wd  (wb_data)
    );

    assign alu_b  = ctl.addr_calc ? imm[XLEN-1:0] : b_q;
    assign alu_op = ctl.exec ? alu_from_fn(ins.fn) : ALU_ADD;

    cpu_alu #(.W(XLEN)) u_alu (
        .op (alu_op),
        .a  (a_q),
        .b  (alu_b),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
            mdr_q <= '0;
            tgt_q <= '0;
        end else begin
            if (ctl.fetch)
                pc <= pc + 1'b1;
            if (ctl.decode) begin
                a_q   <= rd1;
                b_q   <= rd2;
                tgt_q <= pc + {imm[XLEN-3:0], 2'b00};
            end
            if (ctl.addr_calc || ctl.exec)
                alu_q <= alu_y;
            if (ctl.load_rd)
                mdr_q <= mem_rdata;
            if (ctl.branch && a_q == b_q)
                pc <= tgt_q;
            if (ctl.jump)
                pc <= {ir_word[XLEN-3:0], 2'b00};
        end
    end

    assign mem_addr  = ctl.fetch ? pc : alu_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.store;

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.fetch |=> (pc == $past(pc) + 1'b1));

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    assert_branch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch && a_q != b_q) |=> $stable(pc));

    assert_jump_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> (pc[1:0] == 2'b00));
endmodule

// File: tb/byte_cpu_test.sv
module byte_cpu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we;
    logic [7:0] mem [256];

    int n_tests = 0;
    int n_fail  = 0;
    int st_cnt  = 0;
    logic [7:0] st_addr, st_data;

    always #10 clk = ~clk;  // 50 MHz

    byte_cpu uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            st_cnt  = st_cnt + 1;
            st_addr = mem_addr;
            st_data = mem_wdata;
        end
    end

    // {funct, operand1, operand2, expected}
    localparam logic [29:0] VEC [10] = '{
        {6'h20, 8'h05, 8'h02, 8'h07},
        {6'h20, 8'hF0, 8'h20, 8'h10},
        {6'h22, 8'h03, 8'h05, 8'hFE},
        {6'h22, 8'h40, 8'h01, 8'h3F},
        {6'h24, 8'hF0, 8'h3C, 8'h30},
        {6'h25, 8'hA0, 8'h05, 8'hA5},
        {6'h2A, 8'hFF, 8'h01, 8'h01},
        {6'h2A, 8'h01, 8'hFF, 8'h00},
        {6'h2A, 8'h80, 8'h7F, 8'h01},
        {6'h2A, 8'h05, 8'h05, 8'h00}
    };

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int t);
        return {6'h02, 26'(t)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int b = 0; b < 4; b++) mem[(a + b) & 255] = w[b*8 +: 8];
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    endtask

    task automatic release_reset();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        st_cnt = 0;
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // ---- Table walk: ALU operations (R3, R4, R5, R6)
        for (int v = 0; v < 10; v++) begin
            hold_reset();
            mem[8'h80] = VEC[v][23:16];
            mem[8'h81] = VEC[v][15:8];
            put_word(0,  enc_i(6'h20, 0, 1, 16'h0080));
            put_word(4,  enc_i(6'h20, 0, 2, 16'h0081));
            put_word(8,  enc_r(1, 2, 3, VEC[v][29:24]));
            put_word(12, enc_i(6'h28, 0, 3, 16'h0090));
            put_word(16, enc_j(4));
            release_reset();
            if (v == 0) begin
                // R1 reset state at release, R2 fetch address order
                check("R1 reset addr", {24'd0, mem_addr}, 0);
                check("R1 reset strobe", {31'd0, mem_we}, 0);
                for (int k = 1; k < 4; k++) begin
                    @(negedge clk);
                    check("R2 fetch byte address", {24'd0, mem_addr}, k);
                end
            end
            run(70);
            check(VEC[v][29:24] == 6'h2A ? "R4 slt result" : "R3 alu result",
                  {24'd0, mem[8'h90]}, {24'd0, VEC[v][7:0]});
            if (v == 0) begin
                check("R6 single strobe count", st_cnt, 1);
                check("R6 strobe address", {24'd0, st_addr}, 32'h90);
                check("R6 strobe data", {24'd0, st_data}, 32'h07);
            end
        end

        // ---- 5 + 2 stored to address 5 (R3)
        hold_reset();
        mem[8'h80] = 8'd5;
        mem[8'h81] = 8'd2;
        put_word(0,  enc_i(6'h20, 0, 1, 16'h0080));
        put_word(4,  enc_i(6'h20, 0, 2, 16'h0081));
        put_word(8,  enc_r(1, 2, 3, 6'h20));
        put_word(12, enc_i(6'h28, 0, 3, 5));
        put_word(16, enc_j(4));
        release_reset();
        run(70);
        check("R3 value 7 at address 5", {24'd0, mem[5]}, 7);

        // ---- Reset in the middle of a program (R1)
        run(3);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset addr", {24'd0, mem_addr}, 0);
        check("R1 mid-run reset strobe", {31'd0, mem_we}, 0);

        // ---- Register 0 ignores writes (R9)
        hold_reset();
        mem[8'h80] = 8'h11;
        mem[8'h81] = 8'h22;
        put_word(0,  enc_i(6'h20, 0, 1, 16'h0080));
        put_word(4,  enc_i(6'h20, 0, 0, 16'h0081));
        put_word(8,  enc_r(0, 1, 3, 6'h20));
        put_word(12, enc_i(6'h28, 0, 3, 16'h0090));
        put_word(16, enc_j(4));
        release_reset();
        run(70);
        check("R9 register 0 stays zero", {24'd0, mem[8'h90]}, 32'h11);

        // ---- Load through non-zero base register (R5)
        hold_reset();
        mem[8'h80] = 8'h70;
        mem[8'h85] = 8'h5A;
        put_word(0,  enc_i(6'h20, 0, 1, 16'h0080));
        put_word(4,  enc_i(6'h20, 1, 2, 16'h0015));
        put_word(8,  enc_i(6'h28, 0, 2, 16'h0094));
        put_word(12, enc_j(3));
        release_reset();
        run(60);
        check("R5 load base plus offset", {24'd0, mem[8'h94]}, 32'h5A);

        // ---- Branch taken and not taken (R7)
        for (int t = 0; t < 2; t++) begin
            hold_reset();
            mem[8'h80] = 8'h33;
            mem[8'h81] = (t == 0) ? 8'h33 : 8'h34;
            put_word(0,  enc_i(6'h20, 0, 1, 16'h0080));
            put_word(4,  enc_i(6'h20, 0, 2, 16'h0081));
            put_word(8,  enc_i(6'h04, 1, 2, 1));
            put_word(12, enc_i(6'h28, 0, 1, 16'h0090));
            put_word(16, enc_i(6'h28, 0, 2, 16'h0091));
            put_word(20, enc_j(5));
            release_reset();
            run(80);
            check(t == 0 ? "R7 taken skips store" : "R7 not taken runs store",
                  {24'd0, mem[8'h90]}, t == 0 ? 32'hEE : 32'h33);
            check("R7 store after branch", {24'd0, mem[8'h91]}, t == 0 ? 32'h33 : 32'h34);
        end

        // ---- Backward branch offset -1 wraps onto itself (R7)
        hold_reset();
        put_word(0, enc_r(0, 0, 0, 6'h20));
        put_word(4, enc_i(6'h04, 0, 0, -1));
        put_word(8, enc_i(6'h28, 0, 0, 16'h0095));
        release_reset();
        run(100);
        check("R7 backward loop never falls through", {24'd0, mem[8'h95]}, 32'hEE);
        check("R7 backward loop no strobe", st_cnt, 0);

        // ---- Jump skips over code (R8)
        hold_reset();
        mem[8'h80] = 8'h6C;
        put_word(0,  enc_j(4));
        put_word(4,  enc_i(6'h28, 0, 0, 16'h0092));
        put_word(16, enc_i(6'h20, 0, 1, 16'h0080));
        put_word(20, enc_i(6'h28, 0, 1, 16'h0093));
        put_word(24, enc_j(6));
        release_reset();
        run(60);
        check("R8 jump skipped store", {24'd0, mem[8'h92]}, 32'hEE);
        check("R8 jump target executed", {24'd0, mem[8'h93]}, 32'h6C);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule